// File: doc/BRIEF.md
# Frame Start and Pilot Presence Detector

This block sits behind the marker and header correlators of a satellite receiver's frame synchroniser. On each valid symbol it takes two complex correlator outputs and the symbol energy. The first output is for the frame-start marker and the second is for the header signalling field. It decides whether a frame starts at that symbol. It also decides whether that frame carries pilot blocks.

The marker correlation is first delayed by the length of the signalling field. After that delay the two correlation peaks fall on the same symbol. From the aligned pair the block forms two metrics:

- the squared magnitude of the sum of the two correlations;
- the squared magnitude of their difference.

The block weights the symbol energy with one constant per correlator. It sums each weighted stream over that correlator's window and adds the two window sums. It then scales the result down by a fixed ratio and clamps it from below at a programmable floor. This gives a threshold that tracks the signal level.

When either metric rises above the threshold, the block emits a one-cycle frame-start pulse. The metric that fired tells whether the frame has pilots. That answer is latched and held until the next frame start.

Top module: `sof_pilot_detector`

## Requirements
- R1: While `rst_n` is low, `sync_pulse` and `pilot_flag` are 0. Reset also empties the marker delay line and both energy windows, so every sample taken before reset counts as zero afterwards.
- R2: The marker correlation used for sample n is the marker input of the valid sample accepted PLSC_LEN (default 64) valid samples earlier. If fewer samples have been accepted since reset, that value is zero. The signalling correlation is taken from sample n itself.
- R3: The threshold for sample n is max(`thr_floor`, ((K_SOF·S26 + K_PLSC·S64)·K_DOWN) >> DOWN_SHIFT).
  - S26 is the sum of the energies of the last SOF_LEN valid samples, sample n included.
  - S64 is the same sum over the last PLSC_LEN valid samples.
  - The defaults are K_SOF=4, K_PLSC=2, K_DOWN=3 and DOWN_SHIFT=4.
- R4: Metric A is |m+s|² and metric B is |m−s|². Here m is the delayed marker correlation and s is the signalling correlation. A metric detects only when it is strictly greater than the threshold; equality does not count.
- R5: `sync_pulse` is 1 for exactly one clock after the edge that accepts a detecting sample. This happens only when the previous valid sample did not detect. A run of detecting samples gives a single pulse.
- R6: At a pulse, `pilot_flag` becomes 1 if metric A detected and 0 if only metric B detected. Metric A has priority. Between pulses `pilot_flag` holds its value.
- R7: A cycle with `in_valid` low moves no history and changes no detection state. `sync_pulse` is 0 after it and `pilot_flag` keeps its value.
- R8: When the energy windows are small, `thr_floor` alone sets the threshold. A metric equal to the floor does not detect, and a metric one step above it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies all sample inputs in this cycle |
| sof_re | input | CW | Marker correlation, real part (signed) |
| sof_im | input | CW | Marker correlation, imaginary part (signed) |
| plsc_re | input | CW | Signalling-field correlation, real part (signed) |
| plsc_im | input | CW | Signalling-field correlation, imaginary part (signed) |
| sym_energy | input | EW | Per-symbol energy (unsigned) |
| thr_floor | input | FLOOR_W | Lower bound on the detection threshold |
| sync_pulse | output | 1 | One-cycle frame-start indication |
| pilot_flag | output | 1 | Pilots present in the current frame, held between pulses |

## Verification
The assertions assume the following about the inputs:
- `thr_floor` changes only between test phases.
- A reset lasts at least one clock edge.
- In the single-cycle pulse and the held flag, the assertions do not depend on the input values. They rely only on the output stage being updated by valid cycles alone.

The stimulus follows these assumptions:
- It changes the floor only while the block is in reset or quiet.
- It keeps every correlation inside the signed CW range, so the sums cannot wrap.
- Each directed peak is placed exactly one PLSC_LEN lag after its marker peak. Other phases move the peak off that lag to show the alignment matters.
- A long pseudo-random stream with gaps in `in_valid` is checked symbol by symbol against an arithmetic model.

// File: rtl/sfd_pkg.sv
// Shared definitions for the frame start and pilot presence detector.
// Assumes nothing beyond being compiled before the modules that import it.
package sfd_pkg;

    // Result of comparing both metrics against the threshold for one sample.
    typedef enum logic [1:0] {
        DET_NONE    = 2'd0,
        DET_PILOT   = 2'd1,
        DET_NOPILOT = 2'd2
    } det_kind_e;

endpackage

// File: rtl/sfd_delay_line.sv
// Enable-gated shift register of DEPTH stages.
// q presents the word accepted DEPTH enables ago, or zero after reset.
// Assumes DEPTH >= 1.
module sfd_delay_line #(
    parameter int W     = 24,
    parameter int DEPTH = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            // Load the newest word into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[i] <= '0;
                else if (en) stage[i] <= d;
            end
        end else begin : g_tail
            // Move the word one stage further along.
            always_ff @(posedge clk) begin
                if (!rst_n)  stage[i] <= '0;
                else if (en) stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/sfd_moving_sum.sv
// Running sum over the last LEN enabled samples.
// sum_now already includes the sample on the input this cycle.
// Assumes SW can hold LEN times the largest sample.
module sfd_moving_sum #(
    parameter int IW  = 20,
    parameter int LEN = 26,
    parameter int SW  = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [IW-1:0] sample,
    output logic [SW-1:0] sum_now
);

    logic [IW-1:0] oldest;
    logic [SW-1:0] acc;

    sfd_delay_line #(.W(IW), .DEPTH(LEN)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .d     (sample),
        .q     (oldest)
    );

    // Add the sample entering the window and drop the one leaving it.
    always_comb begin
        sum_now = acc + {{(SW-IW){1'b0}}, sample} - {{(SW-IW){1'b0}}, oldest};
    end

    // Keep the sum of the window for the next sample.
    always_ff @(posedge clk) begin
        if (!rst_n)  acc <= '0;
        else if (en) acc <= sum_now;
    end

endmodule

// File: rtl/sfd_metric.sv
// Squared magnitudes of the sum and the difference of two complex values.
// Purely combinational; output widths never overflow.
module sfd_metric #(
    parameter int CW = 12,
    localparam int MW = 2*CW + 3
) (
    input  logic signed [CW-1:0] a_re,
    input  logic signed [CW-1:0] a_im,
    input  logic signed [CW-1:0] b_re,
    input  logic signed [CW-1:0] b_im,
    output logic        [MW-1:0] sum_mag,
    output logic        [MW-1:0] diff_mag
);

    logic signed [CW:0]      sr, si, dr, di;
    logic signed [2*CW+1:0]  sr2, si2, dr2, di2;

    // Form the sum and difference, then square each component.
    always_comb begin
        sr  = a_re + b_re;
        si  = a_im + b_im;
        dr  = a_re - b_re;
        di  = a_im - b_im;
        sr2 = sr * sr;
        si2 = si * si;
        dr2 = dr * dr;
        di2 = di * di;
        sum_mag  = {1'b0, $unsigned(sr2)} + {1'b0, $unsigned(si2)};
        diff_mag = {1'b0, $unsigned(dr2)} + {1'b0, $unsigned(di2)};
    end

endmodule

// File: rtl/sof_pilot_detector.sv
// Frame start and pilot presence detector.
// It aligns the marker correlation to the signalling correlation and builds
// an energy-adaptive, floored threshold. It pulses on the first detecting
// valid sample and records which metric fired.
// Assumes the correlations arrive on the same valid strobe as the energy.
module sof_pilot_detector
    import sfd_pkg::*;
#(
    parameter int CW         = 12,
    parameter int EW         = 12,
    parameter int KW         = 8,
    parameter int SOF_LEN    = 26,
    parameter int PLSC_LEN   = 64,
    parameter int K_SOF      = 4,
    parameter int K_PLSC     = 2,
    parameter int K_DOWN     = 3,
    parameter int DOWN_SHIFT = 4,
    parameter int FLOOR_W    = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [CW-1:0] sof_re,
    input  logic signed [CW-1:0] sof_im,
    input  logic signed [CW-1:0] plsc_re,
    input  logic signed [CW-1:0] plsc_im,
    input  logic [EW-1:0]        sym_energy,
    input  logic [FLOOR_W-1:0]   thr_floor,
    output logic                 sync_pulse,
    output logic                 pilot_flag
);

    localparam int IW   = EW + KW;
    localparam int LMAX = (SOF_LEN > PLSC_LEN) ? SOF_LEN : PLSC_LEN;
    localparam int SW   = IW + $clog2(LMAX + 1);
    localparam int TW   = SW + 1;
    localparam int PW   = TW + KW;
    localparam int MW   = 2*CW + 3;
    localparam int CMP0 = (PW > MW) ? PW : MW;
    localparam int CMPW = (CMP0 > FLOOR_W) ? CMP0 : FLOOR_W;

    localparam logic [KW-1:0] KS = KW'(K_SOF);
    localparam logic [KW-1:0] KP = KW'(K_PLSC);
    localparam logic [KW-1:0] KD = KW'(K_DOWN);

    logic [IW-1:0]   e_sof, e_plsc;
    logic [SW-1:0]   sum_sof, sum_plsc;
    logic [TW-1:0]   thr_raw;
    logic [PW-1:0]   thr_prod;
    logic [CMPW-1:0] thr_down, thr_min, thr_used, a_ext, b_ext;
    logic [2*CW-1:0] sof_dly;
    logic signed [CW-1:0] md_re, md_im;
    logic [MW-1:0]   metric_a, metric_b;
    det_kind_e       kind;
    logic            det_prev;

    // Weight the symbol energy for each correlator's window.
    always_comb begin
        e_sof  = {{KW{1'b0}}, sym_energy} * {{EW{1'b0}}, KS};
        e_plsc = {{KW{1'b0}}, sym_energy} * {{EW{1'b0}}, KP};
    end

    sfd_moving_sum #(.IW(IW), .LEN(SOF_LEN), .SW(SW)) u_sum_sof (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .sample(e_sof), .sum_now(sum_sof)
    );

    sfd_moving_sum #(.IW(IW), .LEN(PLSC_LEN), .SW(SW)) u_sum_plsc (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .sample(e_plsc), .sum_now(sum_plsc)
    );

    sfd_delay_line #(.W(2*CW), .DEPTH(PLSC_LEN)) u_sof_align (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d({sof_re, sof_im}), .q(sof_dly)
    );

    // Split the aligned marker word back into its components.
    always_comb begin
        md_re = signed'(sof_dly[2*CW-1:CW]);
        md_im = signed'(sof_dly[CW-1:0]);
    end

    sfd_metric #(.CW(CW)) u_metric (
        .a_re(md_re), .a_im(md_im), .b_re(plsc_re), .b_im(plsc_im),
        .sum_mag(metric_a), .diff_mag(metric_b)
    );

    // Combine the windows, scale down and clamp at the floor.
    always_comb begin
        thr_raw  = {1'b0, sum_sof} + {1'b0, sum_plsc};
        thr_prod = {{KW{1'b0}}, thr_raw} * {{TW{1'b0}}, KD};
        thr_down = CMPW'(thr_prod >> DOWN_SHIFT);
        thr_min  = CMPW'(thr_floor);
        thr_used = (thr_down > thr_min) ? thr_down : thr_min;
    end

    // Classify the sample, giving the sum metric priority.
    always_comb begin
        a_ext = CMPW'(metric_a);
        b_ext = CMPW'(metric_b);
        if (a_ext > thr_used)      kind = DET_PILOT;
        else if (b_ext > thr_used) kind = DET_NOPILOT;
        else                       kind = DET_NONE;
    end

    // Pulse on the first detecting sample and latch its pilot decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_pulse <= 1'b0;
            pilot_flag <= 1'b0;
            det_prev   <= 1'b0;
        end else if (in_valid) begin
            sync_pulse <= (kind != DET_NONE) && !det_prev;
            det_prev   <= (kind != DET_NONE);
            if ((kind != DET_NONE) && !det_prev)
                pilot_flag <= (kind == DET_PILOT);
        end else begin
            sync_pulse <= 1'b0;
        end
    end

endmodule

// File: rtl/sfd_checker.sv
// Temporal checks on the detector outputs, attached to every instance by bind.
// Assumes a reset of at least one clock edge.
module sfd_checker (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic sync_pulse,
    input logic pilot_flag
);

    logic rst_q;

    // Remember the reset level of the previous edge.
    always_ff @(posedge clk) rst_q <= rst_n;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        (rst_n && !rst_q) |-> (!sync_pulse && !pilot_flag)); // R1

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse); // R5

    AST_PULSE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> $past(in_valid)); // R7

    AST_FLAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_pulse |-> $stable(pilot_flag)); // R6

endmodule

bind sof_pilot_detector sfd_checker u_sfd_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .sync_pulse (sync_pulse),
    .pilot_flag (pilot_flag)
);

// File: tb/sof_pilot_detector_bench.sv
// Self-checking bench: directed phases plus a long pseudo-random stream,
// each symbol compared with an arithmetic model of the requirements.
module sof_pilot_detector_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 12, EW = 12, KW = 8, FLOOR_W = 24;
    localparam int SOF_LEN = 26, PLSC_LEN = 64;
    localparam int K_SOF = 4, K_PLSC = 2, K_DOWN = 3, DOWN_SHIFT = 4;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0, in_valid = 1'b0;
    logic signed [CW-1:0] sof_re = '0, sof_im = '0, plsc_re = '0, plsc_im = '0;
    logic [EW-1:0] sym_energy = '0;
    logic [FLOOR_W-1:0] thr_floor = '0;
    logic sync_pulse, pilot_flag;

    sof_pilot_detector #(
        .CW(CW), .EW(EW), .KW(KW), .SOF_LEN(SOF_LEN), .PLSC_LEN(PLSC_LEN),
        .K_SOF(K_SOF), .K_PLSC(K_PLSC), .K_DOWN(K_DOWN),
        .DOWN_SHIFT(DOWN_SHIFT), .FLOOR_W(FLOOR_W)
    ) u_sof_pilot_detector (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .sof_re(sof_re), .sof_im(sof_im), .plsc_re(plsc_re), .plsc_im(plsc_im),
        .sym_energy(sym_energy), .thr_floor(thr_floor),
        .sync_pulse(sync_pulse), .pilot_flag(pilot_flag)
    );

    int checks = 0, errors = 0;
    int m_re [PLSC_LEN];
    int m_im [PLSC_LEN];
    int m_e  [PLSC_LEN];
    bit m_prev = 0, m_flag = 0;
    int pulses = 0;

    task automatic check(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < PLSC_LEN; i++) begin
            m_re[i] = 0; m_im[i] = 0; m_e[i] = 0;
        end
        m_prev = 0; m_flag = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "sync_pulse in reset", sync_pulse, 1'b0);
        check("R1", "pilot_flag in reset", pilot_flag, 1'b0);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One clock: drive at the falling edge, predict, sample 1 ns after the rising edge.
    task automatic step(bit v, int sre, int sim, int pre, int pim, int e, string tag);
        bit ep, ef, ha, hb;
        longint s26, s64, thr, da, db, a, b;
        @(negedge clk);
        in_valid = v; sof_re = sre[CW-1:0]; sof_im = sim[CW-1:0];
        plsc_re = pre[CW-1:0]; plsc_im = pim[CW-1:0]; sym_energy = e[EW-1:0];
        ep = 0; ef = m_flag;
        if (v) begin
            s26 = e; s64 = e;
            for (int i = 0; i < SOF_LEN-1; i++)  s26 += m_e[i];
            for (int i = 0; i < PLSC_LEN-1; i++) s64 += m_e[i];
            thr = ((K_SOF*s26 + K_PLSC*s64) * K_DOWN) >>> DOWN_SHIFT;
            if (thr < longint'(thr_floor)) thr = thr_floor;
            da = m_re[PLSC_LEN-1] + pre; db = m_im[PLSC_LEN-1] + pim;
            a  = da*da + db*db;
            da = m_re[PLSC_LEN-1] - pre; db = m_im[PLSC_LEN-1] - pim;
            b  = da*da + db*db;
            ha = a > thr; hb = b > thr;
            ep = (ha || hb) && !m_prev;
            if (ep) ef = ha;
            m_prev = ha || hb;
            for (int i = PLSC_LEN-1; i > 0; i--) begin
                m_re[i] = m_re[i-1]; m_im[i] = m_im[i-1]; m_e[i] = m_e[i-1];
            end
            m_re[0] = sre; m_im[0] = sim; m_e[0] = e;
        end
        @(posedge clk);
        #1;
        check(tag, "sync_pulse", sync_pulse, ep);
        check(tag, "pilot_flag", pilot_flag, ef);
        if (ep) pulses++;
        m_flag = ef;
    endtask

    task automatic quiet(int n, int e, string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, e, tag);
    endtask

    initial begin
        int unsigned lf;
        int p0;
        thr_floor = 24'd100;
        do_reset();

        // R2 R6: marker peak then signalling peak exactly PLSC_LEN later, same sign.
        quiet(70, 1000, "R3");
        p0 = pulses;
        step(1, 200, 0, 0, 0, 1000, "R2");
        quiet(PLSC_LEN-1, 1000, "R2");
        step(1, 0, 0, 150, 0, 1000, "R6");
        if (pulses != p0 + 1) begin errors++; $display("FAIL R6 pilot pulse count actual=%0d expected=%0d", pulses-p0, 1); end
        checks++;
        check("R6", "pilot flag set", pilot_flag, 1'b1);

        // R6: opposite sign marks a pilot-free frame; flag then holds while quiet.
        step(1, 200, 0, 0, 0, 1000, "R6");
        quiet(PLSC_LEN-1, 1000, "R6");
        step(1, 0, 0, -150, 0, 1000, "R6");
        check("R6", "pilot flag cleared", pilot_flag, 1'b0);
        quiet(10, 1000, "R6");

        // R2: signalling peak one sample early finds no aligned marker.
        step(1, 200, 0, 0, 0, 1000, "R2");
        quiet(PLSC_LEN-2, 1000, "R2");
        step(1, 0, 0, 150, 0, 1000, "R2");
        quiet(5, 1000, "R2");

        // R7: invalid cycles with large inputs change nothing.
        for (int i = 0; i < 20; i++) step(0, 1500, -900, 1500, 900, 4000, "R7");
        check("R7", "flag held over idle", pilot_flag, 1'b0);

        // R5: two detecting samples in a row give one pulse.
        p0 = pulses;
        step(1, 200, 0, 0, 0, 1000, "R5");
        step(1, 200, 0, 0, 0, 1000, "R5");
        quiet(PLSC_LEN-2, 1000, "R5");
        step(1, 0, 0, 150, 0, 1000, "R5");
        step(1, 0, 0, 150, 0, 1000, "R5");
        quiet(3, 1000, "R5");
        checks++;
        if (pulses != p0 + 1) begin errors++; $display("FAIL R5 pulses in run actual=%0d expected=%0d", pulses-p0, 1); end

        // R3: lower energy drops the threshold so a marker alone detects.
        quiet(70, 500, "R3");
        step(1, 200, 0, 0, 0, 500, "R3");
        quiet(PLSC_LEN-1, 500, "R3");
        step(1, 0, 0, 0, 0, 500, "R3");
        quiet(3, 500, "R3");

        // R8 R4: zero energy leaves the floor alone; equality does not detect.
        do_reset();
        thr_floor = 24'd1024;
        quiet(70, 0, "R8");
        step(1, 0, 0, 32, 0, 0, "R4");
        step(1, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 33, 0, 0, "R8");
        step(1, 0, 0, -20, 24, 0, "R8");
        quiet(3, 0, "R8");

        // R1: a marker seen before reset must not survive it.
        step(1, 600, 0, 0, 0, 0, "R1");
        do_reset();
        thr_floor = 24'd100;
        quiet(PLSC_LEN-1, 0, "R1");
        step(1, 0, 0, 5, 0, 0, "R1");

        // Pseudo-random stream with gaps in valid and occasional peaks.
        do_reset();
        lf = 32'hACE1_2457;
        for (int n = 0; n < 1500; n++) begin
            int sr, si, pr, pi, en;
            bit v;
            lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
            v  = (lf[3:2] != 2'b00);
            sr = int'(lf[10:4]) - 64;  si = int'(lf[17:11]) - 64;
            pr = int'(lf[24:18]) - 64; pi = int'(lf[31:25]) - 64;
            en = int'(lf[9:4]) * 16;
            if (lf[30:26] == 5'd3) begin sr = sr * 20; pr = pr * 20; end
            step(v, sr, si, pr, pi, en, (n % 2 == 0) ? "R4" : "R3");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R5 actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule